// File: doc/BRIEF.md
# Real-Time Tick Counter with Periodic Interrupt

This block keeps a free-running binary count of ticks taken from one of four source tick strobes. The ticks can pass through two optional divide stages, by 32 and by 512, singly or one after the other. Two events come from that count. A compare event fires when a 12-bit window of the count reaches a programmed value. A rollover event fires when the count wraps to zero. A separate periodic channel raises its own flag once every N ticks. Each flag can request an interrupt. A rollover can also raise a wakeup pulse that needs no interrupt enable.

All configuration sits in one 32-bit control word. Its top bit is the master enable. While that bit is low, every piece of counting and flag logic is held in reset at once. When it is set, the reset is released in step with the clock, so the source select and the dividers can be changed safely while the block is off. Software clears the two flags by writing ones to a status port. A debug input can stall all counting when freeze is enabled.

All source strobes are clock enables in the `clk_i` domain. The block is fully synchronous apart from its asynchronous resets.

Top module: `rtc_tick_timer`

## Requirements
- R1: The control word resets to all zeros. A write with `ctrl_we_i` replaces all 32 bits at the next clock edge, and `ctrl_o` shows the stored word. The layout is: [31] enable, [30] compare/rollover interrupt enable, [29] freeze enable, [28] rollover enable, [27:16] compare value, [15] periodic enable, [14] periodic interrupt enable, [13:12] source select, [11] divide-by-512 enable, [10] divide-by-32 enable, [9:0] periodic value.
- R2: Once running, the counter adds one for each tick that reaches it. With both dividers off, that is every cycle in which `src_tick_i[sel]` is high, where sel is field [13:12].
- R3: Divide-by-32 passes one tick in 32 source ticks and divide-by-512 passes one in 512. With both enabled they run in series, 32 first, giving one tick per 16384. A disabled stage passes ticks straight through and holds its count at zero.
- R4: Writing enable = 0 clears the counter, the divider state, the periodic counter, both flags and the wakeup output in that same edge. After enable is written to 1 at edge k, the first count can occur at edge k+3.
- R5: The compare flag sets at the edge where the counter steps into a value whose bits [CMP_LSB+11:CMP_LSB] (default bits 21 to 10) equal a non-zero compare field. A compare field of zero never sets it.
- R6: With rollover enable set, a wrap from all ones to zero sets the compare flag and drives `wakeup_o` high for exactly that one cycle. With rollover enable clear, a wrap does neither.
- R7: `rtc_irq_o` is high exactly when the compare flag is set and bit [30] is 1.
- R8: With freeze enable set and `dbg_i` high, the counter, the dividers and the periodic counter all hold their state, and counting resumes from there once `dbg_i` falls. With freeze enable clear, `dbg_i` has no effect.
- R9: With periodic enable set and a non-zero periodic value N, the periodic flag sets once every N ticks. A value of zero never sets it. With periodic enable clear, the periodic counter is held at zero.
- R10: `api_irq_o` is high exactly when the periodic flag is set and bit [14] is 1.
- R11: A status write with bit [1] set clears the compare flag, and one with bit [0] set clears the periodic flag. Zero bits leave the flags unchanged. A flag set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| src_tick_i | input | 4 | Source tick strobes, one per selectable source |
| dbg_i | input | 1 | Debug-mode indication |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_o | output | 32 | Stored control word |
| stat_we_i | input | 1 | Status write strobe (write one to clear) |
| stat_wdata_i | input | 2 | [1] clear compare flag, [0] clear periodic flag |
| cnt_o | output | CNT_W | Current counter value |
| rtc_flag_o | output | 1 | Compare/rollover flag |
| api_flag_o | output | 1 | Periodic flag |
| rtc_irq_o | output | 1 | Compare/rollover interrupt request |
| api_irq_o | output | 1 | Periodic interrupt request |
| wakeup_o | output | 1 | One-cycle rollover wakeup pulse |

## Verification
A wrong divider or counter state shows up on `cnt_o` in the very next cycle in which a tick reaches the counter. A bad periodic counter moves the rise of `api_flag_o` by at least one tick. A stale synchronizer or flag state after a disable or re-enable shifts the first increment away from edge k+3, so a model that tracks the counter every cycle sees it at once. A wrong rollover path can only be seen at a wrap. For that reason a second instance with a 14-bit counter is run alongside the default one, so that wraps, wakeup pulses and set-against-clear races all occur within a short run.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int unsigned CTRL_W = 32;
  localparam int unsigned CMP_W  = 12;
  localparam int unsigned PER_W  = 10;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned SRC_N  = 1 << SEL_W;

  // Field order is fixed: cnt_en lands on bit 31, per_val on bits 9:0.
  typedef struct packed {
    logic              cnt_en;
    logic              rtc_ie;
    logic              frz_en;
    logic              rov_en;
    logic [CMP_W-1:0]  cmp_val;
    logic              per_en;
    logic              per_ie;
    logic [SEL_W-1:0]  src_sel;
    logic              div512_en;
    logic              div32_en;
    logic [PER_W-1:0]  per_val;
  } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_tick_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              lrst_no
);
  ctrl_t ctrl_q, ctrl_d;
  logic  arst_n;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) ctrl_d = ctrl_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  // Local reset: asserted at once when the enable is low, released through a synchronizer.
  assign arst_n = rst_ni & ctrl_q.cnt_en;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign ctrl_o  = ctrl_q;
  assign lrst_no = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
  parameter int unsigned W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;

  assign at_top = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = en_i ? (tick_i & at_top) : tick_i;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_tick_pkg::*;
#(
  parameter int unsigned FIRST_W  = 5,
  parameter int unsigned SECOND_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  input  logic             first_en_i,
  input  logic             second_en_i,
  output logic             tick_o
);
  localparam int unsigned N_STAGE = 2;
  localparam int unsigned STAGE_W [N_STAGE] = '{FIRST_W, SECOND_W};

  logic [N_STAGE:0]   chain;
  logic [N_STAGE-1:0] stage_en;

  assign chain[0]  = src_tick_i[sel_i] & run_i;
  assign stage_en  = {second_en_i, first_en_i};

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    rtc_div_stage #(.W(STAGE_W[g])) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (stage_en[g]),
      .tick_i (chain[g]),
      .tick_o (chain[g+1])
    );
  end

  assign tick_o = chain[N_STAGE];
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CMP_LSB = 10,
  parameter int unsigned CMP_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             hit_now, hit_next;

  assign cnt_inc  = cnt_q + 1'b1;
  assign hit_now  = (cnt_q[CMP_LSB +: CMP_W] == cmp_val_i);
  assign hit_next = (cnt_inc[CMP_LSB +: CMP_W] == cmp_val_i);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign match_o = tick_i & (|cmp_val_i) & hit_next & ~hit_now;
  assign roll_o  = tick_i & (&cnt_q);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] val_i,
  output logic             evt_o
);
  logic [PER_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             reach;

  assign cnt_inc = cnt_q + 1'b1;
  assign reach   = tick_i & (|val_i) & (cnt_inc == val_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (reach)  cnt_d = '0;
    else if (tick_i) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign evt_o = en_i & reach;
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CMP_LSB = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        src_tick_i,
  input  logic              dbg_i,
  input  logic              ctrl_we_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_o,
  input  logic              stat_we_i,
  input  logic [1:0]        stat_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rtc_flag_o,
  output logic              api_flag_o,
  output logic              rtc_irq_o,
  output logic              api_irq_o,
  output logic              wakeup_o
);
  localparam int unsigned STAT_RTC = 1;
  localparam int unsigned STAT_API = 0;

  ctrl_t ctrl;
  logic  lrst_n, run, tick, match, roll, per_evt;
  logic  rtc_q, rtc_d, api_q, api_d, wake_q, wake_d;

  rtc_ctrl_regs #(.SYNC_STAGES(2)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl),
    .lrst_no (lrst_n)
  );

  assign run = ~(ctrl.frz_en & dbg_i);

  rtc_prescaler #(.FIRST_W(5), .SECOND_W(9)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (lrst_n),
    .src_tick_i  (src_tick_i),
    .sel_i       (ctrl.src_sel),
    .run_i       (run),
    .first_en_i  (ctrl.div32_en),
    .second_en_i (ctrl.div512_en),
    .tick_o      (tick)
  );

  rtc_count_core #(.CNT_W(CNT_W), .CMP_LSB(CMP_LSB), .CMP_W(CMP_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (lrst_n),
    .tick_i    (tick),
    .cmp_val_i (ctrl.cmp_val),
    .cnt_o     (cnt_o),
    .match_o   (match),
    .roll_o    (roll)
  );

  rtc_periodic #(.PER_W(PER_W)) u_per (
    .clk_i  (clk_i),
    .rst_ni (lrst_n),
    .en_i   (ctrl.per_en),
    .tick_i (tick),
    .val_i  (ctrl.per_val),
    .evt_o  (per_evt)
  );

  // Set beats clear in the same cycle.
  always_comb begin
    wake_d = roll & ctrl.rov_en;
    rtc_d  = match | wake_d | (rtc_q & ~(stat_we_i & stat_wdata_i[STAT_RTC]));
    api_d  = per_evt | (api_q & ~(stat_we_i & stat_wdata_i[STAT_API]));
  end

  always_ff @(posedge clk_i or negedge lrst_n) begin
    if (!lrst_n) begin
      rtc_q  <= 1'b0;
      api_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rtc_q  <= rtc_d;
      api_q  <= api_d;
      wake_q <= wake_d;
    end
  end

  assign ctrl_o     = ctrl;
  assign rtc_flag_o = rtc_q;
  assign api_flag_o = api_q;
  assign rtc_irq_o  = rtc_q & ctrl.rtc_ie;
  assign api_irq_o  = api_q & ctrl.per_ie;
  assign wakeup_o   = wake_q;
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_i,
  input logic             ctrl_we_i,
  input logic [31:0]      ctrl_wdata_i,
  input logic [31:0]      ctrl_o,
  input logic             stat_we_i,
  input logic [1:0]       stat_wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             rtc_flag_o,
  input logic             api_flag_o,
  input logic             rtc_irq_o,
  input logic             api_irq_o,
  input logic             wakeup_o
);
  p_ctrl_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o == $past(ctrl_wdata_i)));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> ((cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == '0)));

  p_off_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[31] |-> ((cnt_o == '0) && !rtc_flag_o && !api_flag_o && !wakeup_o));

  p_wake_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o |-> ((cnt_o == '0) && rtc_flag_o));

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_irq_o |-> rtc_flag_o);

  p_freeze_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[31] && ctrl_o[29] && dbg_i && !(ctrl_we_i && !ctrl_wdata_i[31]))
    |=> $stable(cnt_o));

  p_per_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(api_flag_o) |-> $past(ctrl_o[15]));

  p_api_irq_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    api_irq_o |-> api_flag_o);

  p_clear_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rtc_flag_o) |-> ($past(stat_we_i && stat_wdata_i[1]) || !ctrl_o[31]));
endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rtc_ref_model.sv
module rtc_ref_model #(
  parameter int CW  = 32,
  parameter int LSB = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wd,
  input  logic        stat_we,
  input  logic [1:0]  stat_wd,
  input  logic [3:0]  src,
  input  logic        dbg,
  output logic [31:0] m_ctrl,
  output logic [63:0] m_cnt,
  output logic        m_rf,
  output logic        m_af,
  output logic        m_wake
);
  longint mask = (longint'(1) << CW) - 1;
  int age = 0, p32 = 0, p512 = 0, ac = 0;
  logic [31:0] c, nc;
  logic s, t, tt, rs, as;
  logic [63:0] nx;

  initial begin
    m_ctrl = '0; m_cnt = '0; m_rf = 0; m_af = 0; m_wake = 0;
  end

  function automatic int fld(logic [63:0] x);
    return int'((x >> LSB) & 64'hFFF);
  endfunction

  task automatic wipe();
    m_cnt = '0; m_rf = 0; m_af = 0; m_wake = 0;
    p32 = 0; p512 = 0; ac = 0;
  endtask

  always @(posedge clk) begin
    c = m_ctrl;
    if (!rst_n) begin
      m_ctrl = '0; age = 0; wipe();
    end else begin
      nc = ctrl_we ? ctrl_wd : c;
      m_wake = 0;
      if (!nc[31]) begin
        age = 0; wipe();
      end else if (!c[31]) begin
        age = 0;
      end else begin
        if (age == 2) begin
          s = src[c[13:12]] && !(c[29] && dbg);
          t = s;
          if (c[10]) begin t = s && (p32 == 31); if (s) p32 = (p32 + 1) % 32; end
          else p32 = 0;
          if (c[11]) begin tt = t && (p512 == 511); if (t) p512 = (p512 + 1) % 512; t = tt; end
          else p512 = 0;
          rs = 0; as = 0;
          if (t) begin
            nx = (m_cnt + 1) & mask;
            if (c[27:16] != 0 && fld(nx) == int'(c[27:16]) && fld(m_cnt) != int'(c[27:16])) rs = 1;
            if (m_cnt == mask && c[28]) begin rs = 1; m_wake = 1; end
            m_cnt = nx;
          end
          if (!c[15]) ac = 0;
          else if (t) begin
            if (c[9:0] != 0 && ((ac + 1) % 1024) == int'(c[9:0])) begin ac = 0; as = 1; end
            else ac = (ac + 1) % 1024;
          end
          m_rf = rs || (m_rf && !(stat_we && stat_wd[1]));
          m_af = as || (m_af && !(stat_we && stat_wd[0]));
        end
        if (age < 2) age = age + 1;
      end
      m_ctrl = nc;
    end
  end
endmodule

// File: tb/rtc_tick_timer_tb_top.sv
module rtc_tick_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 14;
  localparam int SL = 2;

  localparam logic [31:0] EN   = 32'h8000_0000;
  localparam logic [31:0] RIE  = 32'h4000_0000;
  localparam logic [31:0] FRZ  = 32'h2000_0000;
  localparam logic [31:0] ROV  = 32'h1000_0000;
  localparam logic [31:0] PEN  = 32'h0000_8000;
  localparam logic [31:0] PIE  = 32'h0000_4000;
  localparam logic [31:0] D512 = 32'h0000_0800;
  localparam logic [31:0] D32  = 32'h0000_0400;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0, dbg = 1'b0, ctrl_we = 1'b0, stat_we = 1'b0;
  logic [31:0] ctrl_wd = '0;
  logic [1:0]  stat_wd = '0;
  logic [3:0]  src = 4'b0001;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [31:0]   b_ctrl, s_ctrl;
  logic [31:0]   b_cnt;
  logic [SW-1:0] s_cnt;
  logic b_rf, b_af, b_ri, b_ai, b_wk, s_rf, s_af, s_ri, s_ai, s_wk;
  logic [31:0] mb_ctrl, ms_ctrl;
  logic [63:0] mb_cnt, ms_cnt;
  logic mb_rf, mb_af, mb_wk, ms_rf, ms_af, ms_wk;

  rtc_tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .dbg_i(dbg),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_o(b_ctrl),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wd), .cnt_o(b_cnt),
    .rtc_flag_o(b_rf), .api_flag_o(b_af), .rtc_irq_o(b_ri), .api_irq_o(b_ai),
    .wakeup_o(b_wk));

  rtc_tick_timer #(.CNT_W(SW), .CMP_LSB(SL)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src), .dbg_i(dbg),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_o(s_ctrl),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wd), .cnt_o(s_cnt),
    .rtc_flag_o(s_rf), .api_flag_o(s_af), .rtc_irq_o(s_ri), .api_irq_o(s_ai),
    .wakeup_o(s_wk));

  rtc_ref_model #(.CW(32), .LSB(10)) ref_big (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
    .stat_we(stat_we), .stat_wd(stat_wd), .src(src), .dbg(dbg),
    .m_ctrl(mb_ctrl), .m_cnt(mb_cnt), .m_rf(mb_rf), .m_af(mb_af), .m_wake(mb_wk));

  rtc_ref_model #(.CW(SW), .LSB(SL)) ref_small (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
    .stat_we(stat_we), .stat_wd(stat_wd), .src(src), .dbg(dbg),
    .m_ctrl(ms_ctrl), .m_cnt(ms_cnt), .m_rf(ms_rf), .m_af(ms_af), .m_wake(ms_wk));

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1", "big ctrl", 64'(b_ctrl), 64'(mb_ctrl));
    chk("R2", "big cnt", 64'(b_cnt), mb_cnt);
    chk("R5", "big rtc flag", 64'(b_rf), 64'(mb_rf));
    chk("R9", "big api flag", 64'(b_af), 64'(mb_af));
    chk("R7", "big rtc irq", 64'(b_ri), 64'(mb_rf & mb_ctrl[30]));
    chk("R10", "big api irq", 64'(b_ai), 64'(mb_af & mb_ctrl[14]));
    chk("R6", "big wakeup", 64'(b_wk), 64'(mb_wk));
    chk("R1", "small ctrl", 64'(s_ctrl), 64'(ms_ctrl));
    chk("R2", "small cnt", 64'(s_cnt), ms_cnt);
    chk("R5", "small rtc flag", 64'(s_rf), 64'(ms_rf));
    chk("R9", "small api flag", 64'(s_af), 64'(ms_af));
    chk("R7", "small rtc irq", 64'(s_ri), 64'(ms_rf & ms_ctrl[30]));
    chk("R10", "small api irq", 64'(s_ai), 64'(ms_af & ms_ctrl[14]));
    chk("R6", "small wakeup", 64'(s_wk), 64'(ms_wk));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      cyc++;
      src = {1'b0, 1'($urandom % 2), 1'(cyc % 3 == 0), 1'b1};
    end
  endtask

  task automatic wr(logic [31:0] v);
    ctrl_we = 1'b1; ctrl_wd = v;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic clr(logic [1:0] v, int n);
    stat_we = 1'b1; stat_wd = v;
    step(n);
    stat_we = 1'b0; stat_wd = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(3);                              // R1: reset state all zero
    rst_n = 1'b1;
    step(2);
    // R2: source selection, counting starts at edge k+3 (R4)
    wr(EN); step(20);
    wr(EN | 32'h1000); step(30);
    wr(EN | 32'h2000); step(30);
    wr(EN | 32'h3000); step(10);
    // R4: disable clears at once, re-enable restarts
    wr(32'h0); step(3); wr(EN); step(5);
    // R5: compare with value 1; R11 clear; R7 irq gating
    wr(32'h0); wr(EN | RIE | (32'd1 << 16)); step(1100);
    clr(2'b00, 2);                        // R11: zero bits leave flags
    clr(2'b10, 1); step(5);
    wr(EN | (32'd1 << 16)); step(5);
    // R5: compare value zero never matches
    wr(32'h0); wr(EN | RIE); step(1100);
    // R6: wrap without and with rollover enable
    wr(32'h0); wr(EN | RIE); step(17000);
    wr(32'h0); wr(EN | ROV); step(17000);
    wr(EN | ROV | RIE); step(5);
    // R3: dividers singly and in series
    wr(32'h0); wr(EN | D32); step(200);
    wr(32'h0); wr(EN | D512); step(1100);
    wr(32'h0); wr(EN | D32 | D512); step(33000);
    // R8: freeze with debug, then debug ignored
    wr(32'h0); wr(EN | FRZ | D32); step(40);
    dbg = 1'b1; step(40); dbg = 1'b0; step(40);
    wr(EN | D32); dbg = 1'b1; step(40); dbg = 1'b0;
    // R9 / R10: periodic channel
    wr(32'h0); wr(EN | PEN | PIE | 32'd5); step(60);
    clr(2'b01, 1); step(3);
    wr(EN | PEN | PIE | 32'd1); clr(2'b01, 10); step(3);  // R11: set wins over clear
    wr(32'h0); wr(EN | PEN | PIE); step(1100);
    wr(32'h0); wr(EN | 32'd3); step(20);
    wr(32'h0); step(3);
    done = 1;
    summary();
    $finish;
  end
endmodule